// File: doc/BRIEF.md
# Interlaced NTSC Sync Timing Generator

This block is a free-running raster timing source for a standard-definition video path. A single clock at four times the colour subcarrier rate (315/22 MHz) drives a line counter and a half-line counter. Every video timing strobe is decoded from those two counters and then registered: horizontal sync, vertical sync, composite sync, blanking, a subcarrier-rate square wave, an odd/even field flag and an alternating-line flag.

A frame has 525 lines split into two interlaced fields of 262.5 lines each. The top field starts at the beginning of a line. The bottom field starts at the half-line point, so its vertical sync and vertical-interval pulses are shifted by half a line. In the vertical interval, composite sync carries narrow equalizing pulses and wide serrated pulses at half-line spacing. Horizontal and vertical sync lead the true line start, which is marked by the composite sync edge, by a fixed offset.

A video mixer or overlay stage uses the block by sampling its strobes. A separate input clears only the line-alternation flag, so that flag can be aligned to an outside reference.

Top module: `ntsc_sync_gen`

## Requirements
- R1: A line is 910 clocks and a field is 238875 clocks (525 half-lines of 455 clocks each). The top field starts at line cycle 0 and the bottom field starts at line cycle 455.
- R2: `hsync_n_o` is low for line cycles 0 to 95 and high for the rest of the line.
- R3: `vsync_n_o` is low for the first 18 half-lines (8190 clocks) of each field. It falls at line cycle 0 in the top field and at line cycle 455 in the bottom field.
- R4: Outside the vertical interval, `csync_n_o` is low for line cycles 22 to 89 and high otherwise.
- R5: In field half-lines 0 to 5 and 12 to 17, `csync_n_o` is low for half-line cycles 22 to 53 (32 clocks) and high for the remaining 423 clocks of each half-line.
- R6: In field half-lines 6 to 11, `csync_n_o` is low for half-line cycles 22 to 408 (387 clocks) and high for the remaining 68 clocks of each half-line.
- R7: `blank_n_o` is low for line cycles 0 to 153 of every line, and also for the first 18354 clocks of each field.
- R8: `sc_o` is the clock divided by 4. It is low for the first two cycles after reset and then high for two, counting the reset cycle as cycle 0.
- R9: `odd_field_o` is 1 throughout the top (odd) field and 0 throughout the bottom (even) field.
- R10: `lalt_o` is 0 on the first line after reset and inverts at each line start (line cycle 0), so it is 0 on odd lines and 1 on even lines.
- R11: While `lalt_rst_i` is high at a clock edge, `lalt_o` is 0 after that edge, even at a line start. Inversion resumes at the next line start after `lalt_rst_i` is released.
- R12: A clock edge with `rst_i` high puts the block at cycle 0 of the top field. The outputs then read `hsync_n_o`=0, `vsync_n_o`=0, `csync_n_o`=1, `blank_n_o`=0, `sc_o`=0, `odd_field_o`=1 and `lalt_o`=0. Every output is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at four times the subcarrier rate |
| rst_i | input | 1 | Synchronous reset, active high |
| lalt_rst_i | input | 1 | Clears the line-alternation flag, active high |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| csync_n_o | output | 1 | Composite sync with equalizing and serration pulses, active low |
| blank_n_o | output | 1 | Blanking, active low |
| sc_o | output | 1 | Subcarrier square wave, clock divided by 4 |
| odd_field_o | output | 1 | 1 in the odd (top) field, 0 in the even field |
| lalt_o | output | 1 | Line-alternation flag |

## Verification
The bench does not use the default timing. It builds the block with a 40-clock half-line, 21 lines per frame, two lines each of equalizing and serration, and shortened pulse widths that keep the same ordering as the defaults. With these values one full frame takes 1680 clocks, so both fields, the mid-line start of the bottom field, both equalizing groups, the serration group and the long vertical blank are all compared clock by clock against a cycle-based reference over several frames. Measuring the distance between sync edges covers the line and field periods. The line-alternation reset is held across a line boundary, and a reset is applied in the middle of a run.

// File: rtl/ntsc_sync_pkg.sv
package ntsc_sync_pkg;

    // Decoded sync strobes, all active low except the field flag
    typedef struct packed {
        logic hs_n;
        logic vs_n;
        logic cs_n;
        logic blk_n;
        logic odd;
    } sync_vec_t;

endpackage

// File: rtl/ntsc_hcount.sv
module ntsc_hcount #(
    parameter int  HALF_CLKS = 455,
    localparam int LINE_CLKS = 2 * HALF_CLKS,
    localparam int HW        = $clog2(LINE_CLKS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    output logic [HW-1:0] h_q,
    output logic [HW-1:0] h_d,
    output logic          half_end_o,
    output logic          line_end_o
);

    always_comb begin
        line_end_o = (h_q == HW'(LINE_CLKS - 1));
        half_end_o = line_end_o || (h_q == HW'(HALF_CLKS - 1));
        if (rst_i || line_end_o) begin
            h_d = '0;
        end else begin
            h_d = h_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        h_q <= h_d;
    end

    // R1: the line counter restarts after its last cycle
    assert_line_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        line_end_o |=> (h_q == '0));

endmodule

// File: rtl/ntsc_vcount.sv
module ntsc_vcount #(
    parameter int  FRAME_LINES = 525,
    localparam int FRAME_HALVES = 2 * FRAME_LINES,
    localparam int FW           = $clog2(FRAME_HALVES)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          half_end_i,
    output logic [FW-1:0] hl_d
);

    logic [FW-1:0] hl_q;
    logic          last_half;

    always_comb begin
        last_half = (hl_q == FW'(FRAME_HALVES - 1));
        if (rst_i) begin
            hl_d = '0;
        end else if (half_end_i) begin
            hl_d = last_half ? '0 : hl_q + 1'b1;
        end else begin
            hl_d = hl_q;
        end
    end

    always_ff @(posedge clk_i) begin
        hl_q <= hl_d;
    end

    // R1: the frame holds exactly 2*FRAME_LINES half-lines
    assert_frame_wrap_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (half_end_i && last_half) |=> (hl_q == '0));

endmodule

// File: rtl/ntsc_sync_shape.sv
module ntsc_sync_shape
    import ntsc_sync_pkg::*;
#(
    parameter int  HALF_CLKS   = 455,
    parameter int  FRAME_LINES = 525,
    parameter int  HS_LEN      = 96,
    parameter int  CS_OFS      = 22,
    parameter int  CS_LEN      = 68,
    parameter int  EQ_LEN      = 32,
    parameter int  SER_LEN     = 387,
    parameter int  BLK_LEN     = 154,
    parameter int  VBLK_LEN    = 18354,
    parameter int  EQ_LINES    = 3,
    parameter int  SER_LINES   = 3,
    localparam int LINE_CLKS   = 2 * HALF_CLKS,
    localparam int HW          = $clog2(LINE_CLKS),
    localparam int FW          = $clog2(2 * FRAME_LINES)
) (
    input  logic [HW-1:0] h_i,
    input  logic [FW-1:0] hl_i,
    output sync_vec_t     sync_o
);

    localparam int EQ_HALVES  = 2 * EQ_LINES;
    localparam int SER_HALVES = 2 * SER_LINES;
    localparam int VI_HALVES  = 2 * EQ_HALVES + SER_HALVES;
    localparam int VB_HALVES  = VBLK_LEN / HALF_CLKS;
    localparam int VB_REM     = VBLK_LEN % HALF_CLKS;

    logic          top;
    logic [FW-1:0] fh;
    logic [HW-1:0] pos;
    logic          in_ser;
    logic          in_eq;
    logic          cs_low;
    logic          vb_low;

    always_comb begin
        top    = (hl_i < FW'(FRAME_LINES));
        fh     = top ? hl_i : hl_i - FW'(FRAME_LINES);
        pos    = (h_i >= HW'(HALF_CLKS)) ? h_i - HW'(HALF_CLKS) : h_i;
        in_ser = (fh >= FW'(EQ_HALVES)) && (fh < FW'(EQ_HALVES + SER_HALVES));
        in_eq  = (fh < FW'(VI_HALVES)) && !in_ser;

        if (in_ser) begin
            cs_low = (pos >= HW'(CS_OFS)) && (pos < HW'(CS_OFS + SER_LEN));
        end else if (in_eq) begin
            cs_low = (pos >= HW'(CS_OFS)) && (pos < HW'(CS_OFS + EQ_LEN));
        end else begin
            cs_low = (h_i >= HW'(CS_OFS)) && (h_i < HW'(CS_OFS + CS_LEN));
        end

        vb_low = (fh < FW'(VB_HALVES)) ||
                 ((fh == FW'(VB_HALVES)) && (pos < HW'(VB_REM)));

        sync_o.hs_n  = !(h_i < HW'(HS_LEN));
        sync_o.vs_n  = !(fh < FW'(VI_HALVES));
        sync_o.cs_n  = !cs_low;
        sync_o.blk_n = !((h_i < HW'(BLK_LEN)) || vb_low);
        sync_o.odd   = top;
    end

endmodule

// File: rtl/ntsc_sync_gen.sv
module ntsc_sync_gen
    import ntsc_sync_pkg::*;
#(
    parameter int HALF_CLKS   = 455,
    parameter int FRAME_LINES = 525,
    parameter int HS_LEN      = 96,
    parameter int CS_OFS      = 22,
    parameter int CS_LEN      = 68,
    parameter int EQ_LEN      = 32,
    parameter int SER_LEN     = 387,
    parameter int BLK_LEN     = 154,
    parameter int VBLK_LEN    = 18354,
    parameter int EQ_LINES    = 3,
    parameter int SER_LINES   = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lalt_rst_i,
    output logic hsync_n_o,
    output logic vsync_n_o,
    output logic csync_n_o,
    output logic blank_n_o,
    output logic sc_o,
    output logic odd_field_o,
    output logic lalt_o
);

    localparam int LINE_CLKS = 2 * HALF_CLKS;
    localparam int HW        = $clog2(LINE_CLKS);
    localparam int FW        = $clog2(2 * FRAME_LINES);

    typedef struct packed {
        sync_vec_t  sync;
        logic       lalt;
        logic [1:0] ph;
    } gen_state_t;

    logic [HW-1:0] h_q;
    logic [HW-1:0] h_d;
    logic [FW-1:0] hl_d;
    logic          half_end;
    logic          line_end;
    sync_vec_t     shape;
    gen_state_t    st_d;
    gen_state_t    st_q;

    ntsc_hcount #(.HALF_CLKS(HALF_CLKS)) hcount_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .h_q        (h_q),
        .h_d        (h_d),
        .half_end_o (half_end),
        .line_end_o (line_end)
    );

    ntsc_vcount #(.FRAME_LINES(FRAME_LINES)) vcount_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .half_end_i (half_end),
        .hl_d       (hl_d)
    );

    // Decode from the next counter state so the registered strobes line up with it
    ntsc_sync_shape #(
        .HALF_CLKS   (HALF_CLKS),
        .FRAME_LINES (FRAME_LINES),
        .HS_LEN      (HS_LEN),
        .CS_OFS      (CS_OFS),
        .CS_LEN      (CS_LEN),
        .EQ_LEN      (EQ_LEN),
        .SER_LEN     (SER_LEN),
        .BLK_LEN     (BLK_LEN),
        .VBLK_LEN    (VBLK_LEN),
        .EQ_LINES    (EQ_LINES),
        .SER_LINES   (SER_LINES)
    ) shape_i (
        .h_i    (h_d),
        .hl_i   (hl_d),
        .sync_o (shape)
    );

    always_comb begin
        st_d.sync = shape;
        if (rst_i || lalt_rst_i) begin
            st_d.lalt = 1'b0;
        end else if (line_end) begin
            st_d.lalt = !st_q.lalt;
        end else begin
            st_d.lalt = st_q.lalt;
        end
        st_d.ph = rst_i ? 2'd0 : st_q.ph + 2'd1;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign hsync_n_o   = st_q.sync.hs_n;
    assign vsync_n_o   = st_q.sync.vs_n;
    assign csync_n_o   = st_q.sync.cs_n;
    assign blank_n_o   = st_q.sync.blk_n;
    assign odd_field_o = st_q.sync.odd;
    assign sc_o        = st_q.ph[1];
    assign lalt_o      = st_q.lalt;

    // R2: horizontal sync starts exactly at line cycle 0
    assert_hs_fall_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hsync_n_o) |-> (h_q == '0));

    // R3: vertical sync starts on a line start in the top field and mid-line in the bottom field
    assert_vs_fall_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(vsync_n_o) |-> ((h_q == '0) && odd_field_o) ||
                             ((h_q == HW'(HALF_CLKS)) && !odd_field_o));

    // R4: every composite sync pulse starts at the fixed offset into a half-line
    assert_cs_fall_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(csync_n_o) |-> (h_q == HW'(CS_OFS)) || (h_q == HW'(HALF_CLKS + CS_OFS)));

    // R7: blanking always covers horizontal sync
    assert_blank_cover_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !hsync_n_o |-> !blank_n_o);

    // R8: the subcarrier holds each level for two clocks
    assert_sc_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sc_o) |=> $stable(sc_o));

    // R9: the field flag changes only on a half-line boundary inside vertical sync
    assert_field_edge_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(odd_field_o) |-> ((h_q == '0) || (h_q == HW'(HALF_CLKS))) && !vsync_n_o);

    // R11: the alternation reset forces the flag low on the next cycle
    assert_lalt_clear_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        lalt_rst_i |=> !lalt_o);

endmodule

// File: tb/ntsc_sync_gen_tb.sv
module ntsc_sync_gen_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int HALF_CLKS   = 40;
    localparam int FRAME_LINES = 21;
    localparam int HS_LEN      = 12;
    localparam int CS_OFS      = 3;
    localparam int CS_LEN      = 6;
    localparam int EQ_LEN      = 3;
    localparam int SER_LEN     = 30;
    localparam int BLK_LEN     = 14;
    localparam int VBLK_LEN    = 654;
    localparam int EQ_LINES    = 2;
    localparam int SER_LINES   = 2;

    localparam int LINE_CLKS  = 2 * HALF_CLKS;
    localparam int FIELD_CLKS = FRAME_LINES * HALF_CLKS;
    localparam int FRAME_CLKS = 2 * FIELD_CLKS;
    localparam int EQ_H       = 2 * EQ_LINES;
    localparam int SER_H      = 2 * SER_LINES;
    localparam int VI_CLKS    = (2 * EQ_H + SER_H) * HALF_CLKS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lalt_rst = 1'b0;
    logic hsync_n, vsync_n, csync_n, blank_n, sc, odd_field, lalt;

    int   n = 0;
    logic exp_lalt = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    ntsc_sync_gen #(
        .HALF_CLKS(HALF_CLKS), .FRAME_LINES(FRAME_LINES), .HS_LEN(HS_LEN),
        .CS_OFS(CS_OFS), .CS_LEN(CS_LEN), .EQ_LEN(EQ_LEN), .SER_LEN(SER_LEN),
        .BLK_LEN(BLK_LEN), .VBLK_LEN(VBLK_LEN), .EQ_LINES(EQ_LINES),
        .SER_LINES(SER_LINES)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .lalt_rst_i(lalt_rst),
        .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .csync_n_o(csync_n),
        .blank_n_o(blank_n), .sc_o(sc), .odd_field_o(odd_field), .lalt_o(lalt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Cycle index since reset and the expected line-alternation flag
    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
        if (rst || lalt_rst)              exp_lalt <= 1'b0;
        else if (((n + 1) % LINE_CLKS) == 0) exp_lalt <= ~exp_lalt;
    end

    // Region of cycle m: 0 normal line, 1 equalizing, 2 serration
    function automatic int region(int m);
        int c, fc, vh;
        c  = m % FRAME_CLKS;
        fc = (c < FIELD_CLKS) ? c : c - FIELD_CLKS;
        vh = fc / HALF_CLKS;
        if (fc >= VI_CLKS) return 0;
        if (vh >= EQ_H && vh < EQ_H + SER_H) return 2;
        return 1;
    endfunction

    // Expected output sel at cycle m: 0 hs,1 vs,2 cs,3 blk,4 odd,5 sc,6 lalt
    function automatic logic model(int sel, int m);
        int c, fc, lp, hp, w;
        c  = m % FRAME_CLKS;
        fc = (c < FIELD_CLKS) ? c : c - FIELD_CLKS;
        lp = c % LINE_CLKS;
        hp = c % HALF_CLKS;
        case (sel)
            0: return lp >= HS_LEN;
            1: return fc >= VI_CLKS;
            2: begin
                if (region(m) == 0) return !(lp >= CS_OFS && lp < CS_OFS + CS_LEN);
                w = (region(m) == 2) ? SER_LEN : EQ_LEN;
                return !(hp >= CS_OFS && hp < CS_OFS + w);
            end
            3: return !(lp < BLK_LEN || fc < VBLK_LEN);
            4: return c < FIELD_CLKS;
            5: return (m % 4) >= 2;
            default: return exp_lalt;
        endcase
    endfunction

    function automatic logic actual(int sel);
        case (sel)
            0: return hsync_n;
            1: return vsync_n;
            2: return csync_n;
            3: return blank_n;
            4: return odd_field;
            5: return sc;
            default: return lalt;
        endcase
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at cycle %0d", tag, what, act, exp, n);
        end
    endtask

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare one output against the model each cycle; reg_sel < 0 checks every cycle
    task automatic span(string tag, int sel, int cycles, int reg_sel);
        repeat (cycles) begin
            @(negedge clk);
            if (reg_sel < 0 || region(n) == reg_sel)
                check_bit(tag, "output", actual(sel), model(sel, n));
        end
    endtask

    task automatic t_reset_R12();
        repeat (3) @(negedge clk);
        check_bit("R12", "hsync", hsync_n, 1'b0);
        check_bit("R12", "vsync", vsync_n, 1'b0);
        check_bit("R12", "csync", csync_n, 1'b1);
        check_bit("R12", "blank", blank_n, 1'b0);
        check_bit("R12", "sc", sc, 1'b0);
        check_bit("R12", "odd", odd_field, 1'b1);
        check_bit("R12", "lalt", lalt, 1'b0);
        rst = 1'b0;
        span("R12", 2, 30, -1);
    endtask

    task automatic t_periods_R1();
        int hs_a, hs_b, vs_a, vs_b;
        logic ph, pv;
        hs_a = -1; hs_b = -1; vs_a = -1; vs_b = -1;
        ph = hsync_n; pv = vsync_n;
        repeat (FRAME_CLKS + LINE_CLKS) begin
            @(negedge clk);
            if (ph && !hsync_n) begin
                if (hs_a < 0) hs_a = n; else if (hs_b < 0) hs_b = n;
            end
            if (pv && !vsync_n) begin
                if (vs_a < 0) vs_a = n; else if (vs_b < 0) vs_b = n;
            end
            ph = hsync_n; pv = vsync_n;
        end
        check_int("R1", "line period", hs_b - hs_a, LINE_CLKS);
        check_int("R1", "field period", vs_b - vs_a, FIELD_CLKS);
        check_int("R1", "field start phases", (vs_a % LINE_CLKS) + (vs_b % LINE_CLKS), HALF_CLKS);
    endtask

    task automatic t_hsync_R2();   span("R2", 0, FRAME_CLKS, -1); endtask
    task automatic t_vsync_R3();   span("R3", 1, FRAME_CLKS, -1); endtask
    task automatic t_cs_line_R4(); span("R4", 2, FRAME_CLKS, 0);  endtask
    task automatic t_cs_eq_R5();   span("R5", 2, FRAME_CLKS, 1);  endtask
    task automatic t_cs_ser_R6();  span("R6", 2, FRAME_CLKS, 2);  endtask
    task automatic t_blank_R7();   span("R7", 3, FRAME_CLKS, -1); endtask
    task automatic t_sc_R8();      span("R8", 5, 64, -1);         endtask
    task automatic t_field_R9();   span("R9", 4, FRAME_CLKS, -1); endtask
    task automatic t_lalt_R10();   span("R10", 6, 6 * LINE_CLKS, -1); endtask

    task automatic t_lalt_rst_R11();
        // Hold the clear across a line boundary while the flag is high
        while (!(exp_lalt && (n % LINE_CLKS) == LINE_CLKS - 3)) @(negedge clk);
        check_bit("R11", "flag before clear", lalt, 1'b1);
        lalt_rst = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check_bit("R11", "flag while cleared", lalt, 1'b0);
        end
        lalt_rst = 1'b0;
        span("R11", 6, 3 * LINE_CLKS, -1);
    endtask

    task automatic t_midreset_R12();
        repeat (517) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_bit("R12", "hsync after reset", hsync_n, 1'b0);
        check_bit("R12", "vsync after reset", vsync_n, 1'b0);
        check_bit("R12", "odd after reset", odd_field, 1'b1);
        check_bit("R12", "sc after reset", sc, 1'b0);
        rst = 1'b0;
        span("R12", 1, LINE_CLKS, -1);
        span("R12", 3, LINE_CLKS, -1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        t_reset_R12();
        t_periods_R1();
        t_hsync_R2();
        t_vsync_R3();
        t_cs_line_R4();
        t_cs_eq_R5();
        t_cs_ser_R6();
        t_blank_R7();
        t_sc_R8();
        t_field_R9();
        t_lalt_R10();
        t_lalt_rst_R11();
        t_midreset_R12();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule